// File: doc/BRIEF.md
# ADC conversion status flag register

This block keeps the status word of an analog-to-digital converter sequencer as one 8-bit register. The sequencer pulses event strobes into it: a sequence has finished, a trigger edge has arrived, a result register is being written (with the state of that result's conversion-complete flag), and a result register is being read. A level input reports that a sequence is running. Software sees three sticky flags and a 4-bit count of the results written in the current sequence.

Bus accesses arrive already decoded. There is a write to this register itself, a write to any control or compare register that aborts the running sequence, and a write to the register that starts a new sequence. Flags clear only when software writes a 1 to them. They also clear on the abort and restart causes that apply to each flag, and, for the completion flag alone, on a result read while fast flag clear is enabled. The read value is a combinational view of the flops, so any event shows on the read port one clock after its strobe.

Top module: `adc_stat_reg`

## Requirements
- R1: The read word places the sequence-complete flag at bit 7, a constant 0 at bit 6, the trigger-overrun flag at bit 5, the result-overrun flag at bit 4 and the conversion counter at bits 3..0. Every bit is 0 after reset.
- R2: A `seq_done_i` pulse sets bit 7 at the next clock edge. Further pulses keep it set.
- R3: Bit 7 clears on a register write with data bit 7 = 1, on a start write, or on a result read while `fast_clr_i` = 1. A result read with `fast_clr_i` = 0 leaves it set.
- R4: With `edge_mode_i` = 1, a `trig_edge_i` pulse while `seq_busy_i` = 1 sets bit 5. An edge while `seq_busy_i` = 0 does not set it.
- R5: With `edge_mode_i` = 0, bit 5 never sets, whatever the trigger and busy inputs do.
- R6: Bit 5 clears on a register write with data bit 5 = 1, and bit 4 clears on a register write with data bit 4 = 1. Both clear on an abort write or a start write. A result read clears neither, and an abort does not clear bit 7.
- R7: A `res_wr_i` pulse with `res_ccf_i` = 1 sets bit 4. With `res_ccf_i` = 0 it does not set it.
- R8: Writing 0 to a flag bit leaves that flag unchanged. Register writes never change bits 3..0, whatever data they carry.
- R9: When a set event and a clear event for the same flag fall in one cycle, the flag is 1 afterwards.
- R10: The counter increments by one, modulo 16, on each `res_wr_i` pulse. It loads 0 on an abort or start write. A load in the same cycle as a result write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_done_i | input | 1 | Conversion sequence finished (pulse) |
| trig_edge_i | input | 1 | Active external trigger edge seen (pulse) |
| seq_busy_i | input | 1 | A conversion sequence is in progress |
| edge_mode_i | input | 1 | 1 = edge-sensitive trigger mode, 0 = level-sensitive |
| res_wr_i | input | 1 | A result register is being written (pulse) |
| res_ccf_i | input | 1 | Conversion-complete flag of the result being written is still set |
| res_rd_i | input | 1 | A result register is being read (pulse) |
| fast_clr_i | input | 1 | Fast flag clear mode enabled |
| wr_stat_i | input | 1 | Bus write to this status register |
| wr_data_i | input | 8 | Bus write data |
| wr_abort_i | input | 1 | Bus write to an abort-causing control or compare register |
| wr_start_i | input | 1 | Bus write to the start-sequence register |
| rd_data_o | output | 8 | Status register read value |

## Verification
The read path has no storage of its own, so a wrongly set or cleared flag, or a counter that miscounts, shows on `rd_data_o` one clock after the offending strobe. It stays there until the next clear cause. Any fault in the set/clear decode therefore appears in the first sample after the stimulus that exposes it. A counter that fails to wrap or that accepts bus data shows in bits 3..0 on the very next read. Same-cycle set/clear collisions and load/increment collisions are driven on purpose, because a wrong priority only shows in those cycles.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;

  // Index of each sticky flag inside the flag vector
  localparam int FLG_ROV   = 0;  // result overrun
  localparam int FLG_ETO   = 1;  // external trigger overrun
  localparam int FLG_SCF   = 2;  // sequence complete
  localparam int NUM_FLAGS = 3;

  // Next state of a sticky flag: a set event outranks a clear event
  function automatic logic flag_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

endpackage

// File: rtl/adc_stat_event.sv
module adc_stat_event
  import adc_stat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic                 seq_done_i,
  input  logic                 trig_edge_i,
  input  logic                 seq_busy_i,
  input  logic                 edge_mode_i,
  input  logic                 res_wr_i,
  input  logic                 res_ccf_i,
  input  logic                 res_rd_i,
  input  logic                 fast_clr_i,
  input  logic                 wr_stat_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 wr_abort_i,
  input  logic                 wr_start_i,
  output logic [NUM_FLAGS-1:0] set_o,
  output logic [NUM_FLAGS-1:0] clr_o,
  output logic                 cnt_load_o,
  output logic                 cnt_inc_o
);
  localparam int SCF_POS = DATA_W - 1;
  localparam int ETO_POS = DATA_W - 3;
  localparam int ROV_POS = DATA_W - 4;
  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << SCF_POS) | (DATA_W'(1) << ETO_POS) | (DATA_W'(1) << ROV_POS);

  logic w1c_scf, w1c_eto, w1c_rov;
  logic wr_data_unused;

  assign w1c_scf = wr_stat_i & wr_data_i[SCF_POS];
  assign w1c_eto = wr_stat_i & wr_data_i[ETO_POS];
  assign w1c_rov = wr_stat_i & wr_data_i[ROV_POS];
  // Non-flag bits of the write data are read-only here
  assign wr_data_unused = ^(wr_data_i & ~FLAG_MASK);

  always_comb begin
    set_o          = '0;
    clr_o          = '0;
    set_o[FLG_SCF] = seq_done_i;
    set_o[FLG_ETO] = edge_mode_i & trig_edge_i & seq_busy_i;
    set_o[FLG_ROV] = res_wr_i & res_ccf_i;
    clr_o[FLG_SCF] = w1c_scf | wr_start_i | (fast_clr_i & res_rd_i);
    clr_o[FLG_ETO] = w1c_eto | wr_abort_i | wr_start_i;
    clr_o[FLG_ROV] = w1c_rov | wr_abort_i | wr_start_i;
  end

  assign cnt_load_o = wr_abort_i | wr_start_i;
  assign cnt_inc_o  = res_wr_i;

endmodule

// File: rtl/adc_stat_flag.sv
module adc_stat_flag
  import adc_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= flag_next(q_o, set_i, clr_i);
  end
endmodule

// File: rtl/adc_stat_cnt.sv
module adc_stat_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  // Load-to-zero outranks the increment; wrap is natural modulo 2**CNT_W
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                input logic ld, input logic inc);
    if (ld)       return '0;
    else if (inc) return c + CNT_W'(1);
    else          return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_next(cnt_o, load_i, inc_i);
  end
endmodule

// File: rtl/adc_stat_rdmux.sv
module adc_stat_rdmux
  import adc_stat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output logic [DATA_W-1:0]    word_o
);
  localparam int SCF_POS = DATA_W - 1;
  localparam int ETO_POS = DATA_W - 3;
  localparam int ROV_POS = DATA_W - 4;

  always_comb begin
    word_o            = '0;   // reserved bit and any gap read as zero
    word_o[SCF_POS]   = flags_i[FLG_SCF];
    word_o[ETO_POS]   = flags_i[FLG_ETO];
    word_o[ROV_POS]   = flags_i[FLG_ROV];
    word_o[CNT_W-1:0] = cnt_i;
  end
endmodule

// File: rtl/adc_stat_reg.sv
module adc_stat_reg
  import adc_stat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_done_i,
  input  logic              trig_edge_i,
  input  logic              seq_busy_i,
  input  logic              edge_mode_i,
  input  logic              res_wr_i,
  input  logic              res_ccf_i,
  input  logic              res_rd_i,
  input  logic              fast_clr_i,
  input  logic              wr_stat_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_abort_i,
  input  logic              wr_start_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic                 cnt_load, cnt_inc;
  logic [CNT_W-1:0]     conv_cnt;

  // Named internal events, brought out for the bound checker
  logic scf_set, scf_clr, eto_set, eto_clr, rov_set, rov_clr;
  assign scf_set = flag_set[FLG_SCF];
  assign scf_clr = flag_clr[FLG_SCF];
  assign eto_set = flag_set[FLG_ETO];
  assign eto_clr = flag_clr[FLG_ETO];
  assign rov_set = flag_set[FLG_ROV];
  assign rov_clr = flag_clr[FLG_ROV];

  adc_stat_event #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_event (
    .seq_done_i  (seq_done_i),
    .trig_edge_i (trig_edge_i),
    .seq_busy_i  (seq_busy_i),
    .edge_mode_i (edge_mode_i),
    .res_wr_i    (res_wr_i),
    .res_ccf_i   (res_ccf_i),
    .res_rd_i    (res_rd_i),
    .fast_clr_i  (fast_clr_i),
    .wr_stat_i   (wr_stat_i),
    .wr_data_i   (wr_data_i),
    .wr_abort_i  (wr_abort_i),
    .wr_start_i  (wr_start_i),
    .set_o       (flag_set),
    .clr_o       (flag_clr),
    .cnt_load_o  (cnt_load),
    .cnt_inc_o   (cnt_inc)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    adc_stat_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set[g]),
      .clr_i (flag_clr[g]),
      .q_o   (flag_q[g])
    );
  end

  adc_stat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cnt_load),
    .inc_i  (cnt_inc),
    .cnt_o  (conv_cnt)
  );

  adc_stat_rdmux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rdmux (
    .flags_i (flag_q),
    .cnt_i   (conv_cnt),
    .word_o  (rd_data_o)
  );

endmodule

// File: rtl/adc_stat_chk.sv
module adc_stat_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              seq_done,
  input logic              trig_edge,
  input logic              seq_busy,
  input logic              edge_mode,
  input logic              res_wr,
  input logic              res_ccf,
  input logic              res_rd,
  input logic              fast_clr,
  input logic              wr_stat,
  input logic              wr_abort,
  input logic              wr_start,
  input logic              scf_set,
  input logic              scf_clr,
  input logic              eto_set,
  input logic              eto_clr
);
  localparam int SCF_POS = DATA_W - 1;
  localparam int ETO_POS = DATA_W - 3;
  localparam int ROV_POS = DATA_W - 4;

  logic scf, eto, rov;
  logic [CNT_W-1:0] cnt;
  assign scf = rd_data[SCF_POS];
  assign eto = rd_data[ETO_POS];
  assign rov = rd_data[ROV_POS];
  assign cnt = rd_data[CNT_W-1:0];

  a_r2_scf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    scf_set |=> scf);

  a_r3_scf_clears: assert property (@(posedge clk) disable iff (!rst_n)
    scf_clr && !scf_set |=> !scf);

  a_r3_fast_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    res_rd && fast_clr && !seq_done |=> !scf);

  a_r4_eto_sets: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode && trig_edge && seq_busy |=> eto);

  a_r5_level_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eto) |-> $past(edge_mode));

  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort && !eto_set && !(res_wr && res_ccf) |=> !eto && !rov);

  a_r7_rov_sets: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr && res_ccf |=> rov);

  a_r8_write_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && !res_wr && !wr_abort && !wr_start |=> $stable(cnt));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    eto_set && eto_clr |=> eto);

  a_r10_cnt_inc: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr && !wr_abort && !wr_start |=> (cnt - $past(cnt)) == CNT_W'(1));

  a_r10_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort || wr_start |=> cnt == '0);

endmodule

bind adc_stat_reg adc_stat_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_data   (rd_data_o),
  .seq_done  (seq_done_i),
  .trig_edge (trig_edge_i),
  .seq_busy  (seq_busy_i),
  .edge_mode (edge_mode_i),
  .res_wr    (res_wr_i),
  .res_ccf   (res_ccf_i),
  .res_rd    (res_rd_i),
  .fast_clr  (fast_clr_i),
  .wr_stat   (wr_stat_i),
  .wr_abort  (wr_abort_i),
  .wr_start  (wr_start_i),
  .scf_set   (scf_set),
  .scf_clr   (scf_clr),
  .eto_set   (eto_set),
  .eto_clr   (eto_clr)
);

// File: tb/adc_stat_reg_tb.sv
module adc_stat_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       seq_done, trig_edge, seq_busy, edge_mode;
  logic       res_wr, res_ccf, res_rd, fast_clr;
  logic       wr_stat, wr_abort, wr_start;
  logic [7:0] wr_data;
  logic [7:0] rd_data;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  adc_stat_reg u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_done_i  (seq_done),
    .trig_edge_i (trig_edge),
    .seq_busy_i  (seq_busy),
    .edge_mode_i (edge_mode),
    .res_wr_i    (res_wr),
    .res_ccf_i   (res_ccf),
    .res_rd_i    (res_rd),
    .fast_clr_i  (fast_clr),
    .wr_stat_i   (wr_stat),
    .wr_data_i   (wr_data),
    .wr_abort_i  (wr_abort),
    .wr_start_i  (wr_start),
    .rd_data_o   (rd_data)
  );

  // Vector = {stim[15:0], expected read word[7:0], requirement number[3:0]}
  // stim nibble 3: seq_done trig_edge seq_busy edge_mode
  // stim nibble 2: res_wr res_ccf res_rd fast_clr
  // stim nibble 1: wr_abort wr_start wr_stat data7
  // stim nibble 0: data5 data4 data_low(bits 6 and 3..0) 0
  localparam int NV = 24;
  localparam logic [27:0] VEC [NV] = '{
    {16'b0000_0000_0000_0000, 8'h00, 4'd1},   // R1 idle after reset
    {16'b1000_0000_0000_0000, 8'h80, 4'd2},   // R2 done sets
    {16'b1000_0000_0000_0000, 8'h80, 4'd2},   // R2 stays set
    {16'b0000_0010_0000_0000, 8'h80, 4'd3},   // R3 read without fast clear
    {16'b0000_0011_0000_0000, 8'h00, 4'd3},   // R3 read with fast clear
    {16'b1000_0000_0000_0000, 8'h80, 4'd2},
    {16'b0000_0000_0010_0010, 8'h80, 4'd8},   // R8 zeros to flags, ones to count
    {16'b0000_0000_0011_0000, 8'h00, 4'd3},   // R3 write one clears
    {16'b1000_0000_0000_0000, 8'h80, 4'd2},
    {16'b0000_0000_0100_0000, 8'h00, 4'd3},   // R3 start clears
    {16'b0111_0000_0000_0000, 8'h20, 4'd4},   // R4 edge while busy
    {16'b0000_0000_0010_1000, 8'h00, 4'd6},   // R6 write one clears trigger overrun
    {16'b0101_0000_0000_0000, 8'h00, 4'd4},   // R4 edge while idle
    {16'b0110_0000_0000_0000, 8'h00, 4'd5},   // R5 level mode
    {16'b0000_1000_0000_0000, 8'h01, 4'd7},   // R7 write with flag clear
    {16'b0000_1100_0000_0000, 8'h12, 4'd7},   // R7 write with flag set
    {16'b0000_0011_0000_0000, 8'h12, 4'd6},   // R6 read does not clear
    {16'b0000_0000_0010_0100, 8'h02, 4'd6},   // R6 write one clears result overrun
    {16'b0111_1100_0000_0000, 8'h33, 4'd7},
    {16'b0000_0000_1000_0000, 8'h00, 4'd6},   // R6 abort clears, count loads
    {16'b1111_1100_0100_0000, 8'hB0, 4'd9},   // R9 sets beat start
    {16'b1000_0000_0011_1100, 8'h80, 4'd9},   // R9 sets beat write one
    {16'b1000_0011_0000_0000, 8'h80, 4'd9},   // R9 done beats fast read
    {16'b0000_1000_1000_0000, 8'h80, 4'd10}   // R10 load beats increment
  };

  task automatic drive(input logic [15:0] s);
    {seq_done, trig_edge, seq_busy, edge_mode} = s[15:12];
    {res_wr, res_ccf, res_rd, fast_clr}        = s[11:8];
    {wr_abort, wr_start, wr_stat}              = s[7:5];
    wr_data = {s[4], s[1], s[3], s[2], {4{s[1]}}};
  endtask

  task automatic check(input logic [7:0] exp, input int req, input string what);
    checks++;
    if (rd_data !== exp) begin
      failures++;
      $display("FAIL R%0d %s: rd_data=%h expected=%h", req, what, rd_data, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(16'h0000);
    repeat (3) @(negedge clk);
    check(8'h00, 1, "reset value");            // R1
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][27:12]);
      @(negedge clk);
      check(VEC[i][11:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // R10 counter wrap: clear via start, then sixteen result writes
    drive(16'b0000_0000_0100_0000);
    @(negedge clk);
    drive(16'b0000_1000_0000_0000);
    for (int k = 0; k < 15; k++) @(negedge clk);
    check(8'h0F, 10, "count after fifteen writes");
    @(negedge clk);
    check(8'h00, 10, "count wraps to zero");

    // R1 asynchronous reset clears set flags
    drive(16'b1111_1100_0000_0000);
    @(negedge clk);
    drive(16'h0000);
    rst_n = 1'b0;
    #3;
    check(8'h00, 1, "reset mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule